// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two unsigned operands of `WIDTH` bits and trades accuracy in the least significant bits for a shorter carry chain. The operand bits are divided at position `OR_BITS`. Below that position, each result bit is the logical OR of the two operand bits, and no carry is formed there. At and above that position, a ripple-carry chain adds the operands exactly. The chain starts with a carry-in of zero and its carry-out becomes the top result bit.

The block is intended for accumulation stages in approximate matrix-multiply datapaths. In those stages a small, bounded error in the low bits is acceptable if it removes adder logic. The block is purely combinational and has no pipelining or error compensation.

`OR_BITS` may be set to any value from 0 to `WIDTH`. With 0 the block is an exact adder. With `WIDTH` it becomes a bitwise OR with a zero top bit. Any other value is rejected at elaboration.

Top module: `approx_or_adder`

## Requirements
- R1: Result bits [OR_BITS-1:0] equal the bitwise OR of the corresponding bits of `op_a` and `op_b`.
- R2: Result bits [WIDTH-1:OR_BITS] equal the low bits of the exact sum (op_a >> OR_BITS) + (op_b >> OR_BITS). Carries that the low bits would produce never enter this part.
- R3: Result bit [WIDTH] is the carry-out of the upper-part addition (op_a >> OR_BITS) + (op_b >> OR_BITS).
- R4: With OR_BITS = 0 the result equals the exact (WIDTH+1)-bit sum op_a + op_b for every operand pair.
- R5: With OR_BITS = WIDTH the result equals {1'b0, op_a | op_b} for every operand pair, so bit [WIDTH] is always 0.
- R6: The result is never greater than the exact sum op_a + op_b. It is never more than 2^OR_BITS − 1 below that sum.
- R7: When either operand is zero the result equals the other operand exactly. This includes both operands zero giving 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Approximate sum; bit WIDTH is the upper chain's carry-out |

## Verification
The two functions that can occur on the same input pair are the discarded carry of the OR section and the carry-out of the ripple section. An example is both operands having a 1 in the same low bit while their upper fields overflow. The bench sweeps every pair of 6-bit operands, so every combination of low-bit collision and upper overflow occurs. It judges each result against an arithmetic model built from shifted exact sums, and it checks that the error stays within the R6 bound. Two extra instances at OR_BITS = 0 and OR_BITS = WIDTH receive the same sweep to cover both limits of the split.

// File: rtl/approx_or_adder_pkg.sv
package approx_or_adder_pkg;

   // Width of the exact (ripple) section for a given split.
   function automatic int upper_bits(input int width, input int or_bits);
      return width - or_bits;
   endfunction

   // True when the split position lies inside the legal range.
   function automatic bit split_ok(input int width, input int or_bits);
      return (width >= 1) && (or_bits >= 0) && (or_bits <= width);
   endfunction

endpackage

// File: rtl/approx_or_adder_fa.sv
module approx_or_adder_fa (
   input  logic x,
   input  logic y,
   input  logic cin,
   output logic s,
   output logic cout
);
   logic prop;

   assign prop = x ^ y;
   assign s    = prop ^ cin;
   assign cout = (x & y) | (prop & cin);
endmodule

// File: rtl/approx_or_adder_lower.sv
module approx_or_adder_lower #(
   parameter int LW = 2
) (
   input  logic [LW-1:0] x,
   input  logic [LW-1:0] y,
   output logic [LW-1:0] o
);
   initial begin
      if (LW < 1) $error("approx_or_adder_lower: LW must be at least 1");
   end

   // One carry-free cell per bit.
   for (genvar i = 0; i < LW; i++) begin : g_bit
      assign o[i] = x[i] | y[i];
   end
endmodule

// File: rtl/approx_or_adder_ripple.sv
module approx_or_adder_ripple #(
   parameter int UW = 4
) (
   input  logic [UW-1:0] x,
   input  logic [UW-1:0] y,
   output logic [UW-1:0] s,
   output logic          cout
);
   logic [UW:0] carry;

   initial begin
      if (UW < 1) $error("approx_or_adder_ripple: UW must be at least 1");
   end

   // Carry-in of the exact section is tied low: low-part carries are dropped.
   assign carry[0] = 1'b0;

   for (genvar i = 0; i < UW; i++) begin : g_stage
      approx_or_adder_fa u_fa (
         .x    (x[i]),
         .y    (y[i]),
         .cin  (carry[i]),
         .s    (s[i]),
         .cout (carry[i+1])
      );
   end

   assign cout = carry[UW];
endmodule

// File: rtl/approx_or_adder.sv
module approx_or_adder
   import approx_or_adder_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int OR_BITS = 3
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH:0]   sum
);
   localparam int UPPER = upper_bits(WIDTH, OR_BITS);

   initial begin
      if (!split_ok(WIDTH, OR_BITS))
         $error("approx_or_adder: need WIDTH >= 1 and 0 <= OR_BITS <= WIDTH");
   end

   generate
      if (OR_BITS == 0) begin : g_exact
         // Whole word goes through the ripple chain.
         logic [WIDTH-1:0] hi_s;
         logic             hi_c;
         approx_or_adder_ripple #(.UW(WIDTH)) u_hi (
            .x    (op_a),
            .y    (op_b),
            .s    (hi_s),
            .cout (hi_c)
         );
         assign sum = {hi_c, hi_s};
      end else if (OR_BITS == WIDTH) begin : g_all_or
         // No exact section remains; carry-out is constant zero.
         logic [WIDTH-1:0] lo_o;
         approx_or_adder_lower #(.LW(WIDTH)) u_lo (
            .x (op_a),
            .y (op_b),
            .o (lo_o)
         );
         assign sum = {1'b0, lo_o};
      end else begin : g_split
         logic [OR_BITS-1:0] lo_o;
         logic [UPPER-1:0]   hi_s;
         logic               hi_c;
         approx_or_adder_lower #(.LW(OR_BITS)) u_lo (
            .x (op_a[OR_BITS-1:0]),
            .y (op_b[OR_BITS-1:0]),
            .o (lo_o)
         );
         approx_or_adder_ripple #(.UW(UPPER)) u_hi (
            .x    (op_a[WIDTH-1:OR_BITS]),
            .y    (op_b[WIDTH-1:OR_BITS]),
            .s    (hi_s),
            .cout (hi_c)
         );
         assign sum = {hi_c, hi_s, lo_o};
      end
   endgenerate
endmodule

// File: rtl/approx_or_adder_chk.sv
module approx_or_adder_chk #(
   parameter int WIDTH   = 8,
   parameter int OR_BITS = 3
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [WIDTH:0]   sum
);
   localparam logic [WIDTH:0] LOW_MASK =
      ({(WIDTH+1){1'b1}} >> (WIDTH + 1 - OR_BITS));

   logic [WIDTH:0] exact;
   logic [WIDTH:0] upper_ref;
   logic [WIDTH:0] ext_a;
   logic [WIDTH:0] ext_b;

   assign ext_a     = {1'b0, op_a};
   assign ext_b     = {1'b0, op_b};
   assign exact     = ext_a + ext_b;
   assign upper_ref = (ext_a >> OR_BITS) + (ext_b >> OR_BITS);

   always_comb begin
      // R1: low field is the OR of the operands
      assert_low_or_R1: assert ((sum & LOW_MASK) == ((ext_a | ext_b) & LOW_MASK))
         else $error("R1 low field mismatch");
      // R2 and R3: upper field and carry-out follow the shifted exact sum
      assert_upper_exact_R2: assert ((sum >> OR_BITS) == upper_ref)
         else $error("R2/R3 upper field mismatch");
      // R6: never above the exact sum
      assert_not_above_R6: assert (sum <= exact)
         else $error("R6 result above exact sum");
      // R6: error bounded by the low-field weight
      assert_err_bound_R6: assert ((exact - sum) <= LOW_MASK)
         else $error("R6 error bound exceeded");
      // R7: a zero operand leaves the other one unchanged
      assert_zero_pass_R7: assert (!(op_a == '0) || (sum == ext_b))
         else $error("R7 zero operand pass-through");
      if (OR_BITS == WIDTH) begin
         // R5: pure OR configuration never carries out
         assert_no_carry_R5: assert (sum[WIDTH] == 1'b0)
            else $error("R5 carry-out set");
      end
      if (OR_BITS == 0) begin
         // R4: exact configuration
         assert_exact_R4: assert (sum == exact)
            else $error("R4 exact sum mismatch");
      end
   end
endmodule

bind approx_or_adder approx_or_adder_chk #(.WIDTH(WIDTH), .OR_BITS(OR_BITS)) u_chk (
   .op_a (op_a),
   .op_b (op_b),
   .sum  (sum)
);

// File: tb/approx_or_adder_test.sv
module approx_or_adder_test;
   localparam int W  = 6;
   localparam int L  = 2;
   localparam int WATCHDOG_CYCLES = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W:0]   s_mid;
   logic [W:0]   s_exact;
   logic [W:0]   s_or;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   approx_or_adder #(.WIDTH(W), .OR_BITS(L)) uut (
      .op_a (a), .op_b (b), .sum (s_mid)
   );
   approx_or_adder #(.WIDTH(W), .OR_BITS(0)) uut_exact (
      .op_a (a), .op_b (b), .sum (s_exact)
   );
   approx_or_adder #(.WIDTH(W), .OR_BITS(W)) uut_or (
      .op_a (a), .op_b (b), .sum (s_or)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
      end
   endtask

   initial begin
      int ex, lo_mask, up, want;
      lo_mask = (1 << L) - 1;
      repeat (3) @(negedge clk);
      // Reset state: zero operands give zero result (R7)
      check(s_mid == 0,   "R7 reset mid",   s_mid,   0);
      check(s_exact == 0, "R7 reset exact", s_exact, 0);
      check(s_or == 0,    "R7 reset or",    s_or,    0);
      rst = 1'b0;
      for (int i = 0; i < (1 << W); i++) begin
         for (int j = 0; j < (1 << W); j++) begin
            @(posedge clk);
            a = W'(i);
            b = W'(j);
            @(negedge clk);
            ex   = i + j;
            up   = (i >> L) + (j >> L);
            want = (up << L) | ((i | j) & lo_mask);
            check((s_mid & lo_mask) == ((i | j) & lo_mask), "R1",
                  s_mid & lo_mask, (i | j) & lo_mask);
            check((s_mid >> L) % (1 << (W - L)) == up % (1 << (W - L)), "R2",
                  (s_mid >> L) % (1 << (W - L)), up % (1 << (W - L)));
            check(s_mid[W] == (up >= (1 << (W - L))), "R3",
                  s_mid[W], (up >= (1 << (W - L))));
            check(s_mid == want, "R1/R2/R3 full word", s_mid, want);
            check(s_exact == ex, "R4", s_exact, ex);
            check(s_or == (i | j), "R5", s_or, i | j);
            check(s_mid <= ex && (ex - s_mid) <= lo_mask, "R6", s_mid, ex);
            if (i == 0) check(s_mid == j, "R7 a zero", s_mid, j);
            if (j == 0) check(s_mid == i, "R7 b zero", s_mid, i);
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule